// File: doc/BRIEF.md
# DMA Translation Control Register Bank

This block holds the software-visible configuration and fault-reporting state of a DMA address-translation unit. A host reaches it over a plain 32-bit register bus (byte address, read strobe, write strobe, byte enables, write data, read data). Only aligned full-word accesses take effect. Each register keeps its own set of writable bits. Some registers also hold bits that are always set, and one register only ever gains bits. Reads return data combinationally in the cycle of the read strobe. Writes take effect at the next clock edge.

The translation engine uses two exported values: the page-table base and a window mask. The window mask is decoded from a three-bit size code in the control register whenever that register is written. When the engine hits a fault, it pulses a capture strobe that loads the fault status and the fault address. The same strobe raises a level interrupt. Software clears the interrupt by reading or writing either fault register.

Top module: `dmat_cfg_regs`

## Requirements
- R1: After reset, reads return these values: control = VERSION in bits 31:24 with zeros below; base = 0; fault status = 0x00800000; fault address = 0; arbiter-enable = 0x00000003; arbitration = 0x00000008; mask-ID = 0x23000000; slot registers = 0. The outputs `win_mask_o`, `irq_o` and `xlat_en_o` are 0.
- R2: Writing control (byte 0x0000) stores data & 0x0000001D, with VERSION placed in bits 31:24. Bit 0 of control drives `xlat_en_o`.
- R3: A control write sets `win_mask_o` to 0xFFFFFFFF shifted left by (24 + code), where code is data bits 4:2. Code 0 gives 0xFF000000 (16 MB) and code 7 gives 0x80000000 (2 GB).
- R4: The base register (byte 0x0004) keeps data & 0x07FFFC00 and drives `pt_base_o`.
- R5: A write to fault status (byte 0x1000) stores (data & 0xFF0FFFFF) with bit 23 forced to 1. A write to fault address (byte 0x1004) stores the data unchanged.
- R6: A one-cycle `flt_capture` loads fault status with (flt_status & 0xFF0FFFFF) | 0x00800000, loads fault address with `flt_addr`, and sets `irq_o` from the next cycle. If a bus access to a fault register falls in the same cycle, the capture takes effect and the bus write is dropped.
- R7: A full-word read or write of byte 0x1000 or 0x1004, with no capture in that cycle, clears `irq_o` from the next cycle.
- R8: The arbiter-enable register (byte 0x1008) keeps data & 0x801F000F, with bit 0 forced to 1.
- R9: The four slot registers (bytes 0x1010, 0x1014, 0x1018, 0x101C) each keep data & 0x00010003, independently of one another.
- R10: The arbitration register (byte 0x2000) keeps data & 0x001F0000, with bit 3 forced to 1.
- R11: A write to the mask-ID register (byte 0x3018) ORs data & 0x00FFFFFF into its current value. Its bits are never cleared by a write.
- R12: An access to an unlisted offset reads 0 and a write to it changes nothing. An access with byte enables other than 4'hF, or with address bits 1:0 not 0, is ignored: it reads 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 14 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| flt_capture | input | 1 | One-cycle fault capture strobe from the translation engine |
| flt_status | input | 32 | Fault status value to capture |
| flt_addr | input | 32 | Faulting address to capture |
| pt_base_o | output | 32 | Page-table base register value |
| win_mask_o | output | 32 | Decoded DMA window mask |
| xlat_en_o | output | 1 | Translation enable (control bit 0) |
| irq_o | output | 1 | Level fault interrupt |

## Verification
The assertions assume that `flt_capture` is a synchronous, single-cycle strobe. They also assume that the bus strobes and data are stable around the sampling edge. The bench drives every input on the falling clock edge and holds it for one full cycle, so each access and each capture is seen at exactly one rising edge. The bench deliberately overlaps a capture with a fault-register write, so that the precedence rule is exercised within those assumptions rather than outside them.

// File: rtl/dmat_cfg_pkg.sv
package dmat_cfg_pkg;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 32;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int NSLOT  = 4;
    localparam int WIN_BASE_SHIFT = 24;

    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [DATA_W-1:0] word_t;

    // word indices (byte offset >> 2)
    localparam widx_t IDX_CTRL   = 12'h000;
    localparam widx_t IDX_BASE   = 12'h001;
    localparam widx_t IDX_FSTAT  = 12'h400;
    localparam widx_t IDX_FADDR  = 12'h401;
    localparam widx_t IDX_ARBEN  = 12'h402;
    localparam widx_t IDX_SLOT0  = 12'h404;
    localparam widx_t IDX_ARBIT  = 12'h800;
    localparam widx_t IDX_MASKID = 12'hC06;

    localparam word_t CTRL_WMASK   = 32'h0000_001D;
    localparam word_t BASE_WMASK   = 32'h07FF_FC00;
    localparam word_t FSTAT_WMASK  = 32'hFF0F_FFFF;
    localparam word_t FSTAT_FORCE  = 32'h0080_0000;
    localparam word_t ARBEN_WMASK  = 32'h801F_000F;
    localparam word_t ARBEN_FORCE  = 32'h0000_0001;
    localparam word_t SLOT_WMASK   = 32'h0001_0003;
    localparam word_t ARBIT_WMASK  = 32'h001F_0000;
    localparam word_t ARBIT_FORCE  = 32'h0000_0008;
    localparam word_t MASKID_WMASK = 32'h00FF_FFFF;

    localparam word_t ARBEN_RST  = 32'h0000_0003;
    localparam word_t ARBIT_RST  = 32'h0000_0008;
    localparam word_t MASKID_RST = 32'h2300_0000;
endpackage

// File: rtl/dmat_win_decode.sv
module dmat_win_decode
    import dmat_cfg_pkg::*;
(
    input  logic [2:0] size_code,
    output word_t      win_mask
);
    always_comb begin
        win_mask = '1;
        win_mask = win_mask << (WIN_BASE_SHIFT + int'(size_code));
    end
endmodule

// File: rtl/dmat_cfg_store.sv
module dmat_cfg_store
    import dmat_cfg_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'hA5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  widx_t widx,
    input  word_t wdata,
    output word_t ctrl_q,
    output word_t base_q,
    output word_t arben_q,
    output word_t arbit_q,
    output word_t maskid_q,
    output word_t win_q,
    output logic [NSLOT-1:0][DATA_W-1:0] slot_q
);
    localparam word_t CTRL_RST = {VERSION, 24'h0};

    typedef struct packed {
        word_t ctrl;
        word_t base;
        word_t arben;
        word_t arbit;
        word_t maskid;
        word_t win;
        logic [NSLOT-1:0][DATA_W-1:0] slot;
    } store_t;

    store_t st_d, st_q;
    word_t  dec_mask;

    dmat_win_decode u_dec (
        .size_code (wdata[4:2]),
        .win_mask  (dec_mask)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (widx == IDX_CTRL) begin
                st_d.ctrl = (wdata & CTRL_WMASK) | CTRL_RST;
                st_d.win  = dec_mask;
            end
            if (widx == IDX_BASE)   st_d.base   = wdata & BASE_WMASK;
            if (widx == IDX_ARBEN)  st_d.arben  = (wdata & ARBEN_WMASK) | ARBEN_FORCE;
            if (widx == IDX_ARBIT)  st_d.arbit  = (wdata & ARBIT_WMASK) | ARBIT_FORCE;
            if (widx == IDX_MASKID) st_d.maskid = st_q.maskid | (wdata & MASKID_WMASK);
            for (int i = 0; i < NSLOT; i++) begin
                if (widx == IDX_SLOT0 + widx_t'(i)) st_d.slot[i] = wdata & SLOT_WMASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl   <= CTRL_RST;
            st_q.base   <= '0;
            st_q.arben  <= ARBEN_RST;
            st_q.arbit  <= ARBIT_RST;
            st_q.maskid <= MASKID_RST;
            st_q.win    <= '0;
            st_q.slot   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q   = st_q.ctrl;
    assign base_q   = st_q.base;
    assign arben_q  = st_q.arben;
    assign arbit_q  = st_q.arbit;
    assign maskid_q = st_q.maskid;
    assign win_q    = st_q.win;
    assign slot_q   = st_q.slot;

    AST_CTRL_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[31:24] == VERSION); // R2
    AST_WIN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == '0) || ($countones((~win_q) + 32'd1) == 1)); // R3
    AST_ARBEN_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        arben_q[0]); // R8
    AST_ARBIT_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
        arbit_q[3]); // R10
    AST_MASKID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (maskid_q & $past(maskid_q)) == $past(maskid_q)); // R11
endmodule

// File: rtl/dmat_fault_unit.sv
module dmat_fault_unit
    import dmat_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  rd_en,
    input  widx_t widx,
    input  word_t wdata,
    input  logic  cap,
    input  word_t cap_status,
    input  word_t cap_addr,
    output word_t fstat_q,
    output word_t faddr_q,
    output logic  irq_q
);
    typedef struct packed {
        word_t stat;
        word_t addr;
        logic  irq;
    } fault_t;

    fault_t f_d, f_q;
    logic   hit_any;

    assign hit_any = (wr_en || rd_en) && ((widx == IDX_FSTAT) || (widx == IDX_FADDR));

    always_comb begin
        f_d = f_q;
        if (cap) begin
            f_d.stat = (cap_status & FSTAT_WMASK) | FSTAT_FORCE;
            f_d.addr = cap_addr;
            f_d.irq  = 1'b1;
        end else begin
            if (wr_en && widx == IDX_FSTAT) f_d.stat = (wdata & FSTAT_WMASK) | FSTAT_FORCE;
            if (wr_en && widx == IDX_FADDR) f_d.addr = wdata;
            if (hit_any) f_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.stat <= FSTAT_FORCE;
            f_q.addr <= '0;
            f_q.irq  <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign fstat_q = f_q.stat;
    assign faddr_q = f_q.addr;
    assign irq_q   = f_q.irq;

    AST_STATUS_BIT23: assert property (@(posedge clk) disable iff (!rst_n)
        fstat_q[23]); // R5
    AST_CAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> irq_q); // R6
    AST_CAP_LOADS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (faddr_q == $past(cap_addr))); // R6
    AST_ACCESS_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && hit_any) |=> !irq_q); // R7
endmodule

// File: rtl/dmat_cfg_regs.sv
module dmat_cfg_regs
    import dmat_cfg_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              flt_capture,
    input  logic [DATA_W-1:0] flt_status,
    input  logic [DATA_W-1:0] flt_addr,
    output logic [DATA_W-1:0] pt_base_o,
    output logic [DATA_W-1:0] win_mask_o,
    output logic              xlat_en_o,
    output logic              irq_o
);
    logic  full_word, wr_ok, rd_ok;
    widx_t widx;
    word_t ctrl_q, base_q, arben_q, arbit_q, maskid_q, win_q, fstat_q, faddr_q;
    logic [NSLOT-1:0][DATA_W-1:0] slot_q;

    assign full_word = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00); // R12
    assign wr_ok     = bus_wr && full_word;
    assign rd_ok     = bus_rd && full_word;
    assign widx      = bus_addr[ADDR_W-1:2];

    dmat_cfg_store #(.VERSION(VERSION)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .widx     (widx),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .base_q   (base_q),
        .arben_q  (arben_q),
        .arbit_q  (arbit_q),
        .maskid_q (maskid_q),
        .win_q    (win_q),
        .slot_q   (slot_q)
    );

    dmat_fault_unit u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ok),
        .rd_en      (rd_ok),
        .widx       (widx),
        .wdata      (bus_wdata),
        .cap        (flt_capture),
        .cap_status (flt_status),
        .cap_addr   (flt_addr),
        .fstat_q    (fstat_q),
        .faddr_q    (faddr_q),
        .irq_q      (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            if (widx == IDX_CTRL)   bus_rdata = ctrl_q;
            if (widx == IDX_BASE)   bus_rdata = base_q;
            if (widx == IDX_FSTAT)  bus_rdata = fstat_q;
            if (widx == IDX_FADDR)  bus_rdata = faddr_q;
            if (widx == IDX_ARBEN)  bus_rdata = arben_q;
            if (widx == IDX_ARBIT)  bus_rdata = arbit_q;
            if (widx == IDX_MASKID) bus_rdata = maskid_q;
            for (int i = 0; i < NSLOT; i++) begin
                if (widx == IDX_SLOT0 + widx_t'(i)) bus_rdata = slot_q[i];
            end
        end
    end

    assign pt_base_o  = base_q;
    assign win_mask_o = win_q;
    assign xlat_en_o  = ctrl_q[0];

    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |-> (bus_rdata == '0)); // R12
endmodule

// File: tb/dmat_cfg_regs_tb_top.sv
module dmat_cfg_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] VER = 8'hA5;

    typedef struct packed {
        logic [13:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VEC [NVEC] = '{
        '{14'h0000, 32'hFFFF_FFFF, 32'hA500_001D, 8'd2},   // R2
        '{14'h0000, 32'h0000_0000, 32'hA500_0000, 8'd2},   // R2
        '{14'h0004, 32'hFFFF_FFFF, 32'h07FF_FC00, 8'd4},   // R4
        '{14'h1000, 32'h0000_0000, 32'h0080_0000, 8'd5},   // R5
        '{14'h1000, 32'hFFFF_FFFF, 32'hFF8F_FFFF, 8'd5},   // R5
        '{14'h1004, 32'h1234_5678, 32'h1234_5678, 8'd5},   // R5
        '{14'h1008, 32'h0000_0000, 32'h0000_0001, 8'd8},   // R8
        '{14'h1008, 32'hFFFF_FFFF, 32'h801F_000F, 8'd8},   // R8
        '{14'h1010, 32'hFFFF_FFFF, 32'h0001_0003, 8'd9},   // R9
        '{14'h1014, 32'h0001_0001, 32'h0001_0001, 8'd9},   // R9
        '{14'h1018, 32'hFFFE_FFFE, 32'h0000_0002, 8'd9},   // R9
        '{14'h101C, 32'h0000_FFFF, 32'h0000_0003, 8'd9},   // R9
        '{14'h2000, 32'h0000_0000, 32'h0000_0008, 8'd10},  // R10
        '{14'h2000, 32'hFFFF_FFFF, 32'h001F_0008, 8'd10},  // R10
        '{14'h3018, 32'h0000_00F0, 32'h2300_00F0, 8'd11},  // R11
        '{14'h3018, 32'h0000_000F, 32'h2300_00FF, 8'd11},  // R11
        '{14'h3018, 32'hFF00_0000, 32'h2300_00FF, 8'd11},  // R11
        '{14'h0014, 32'hFFFF_FFFF, 32'h0000_0000, 8'd12}   // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flt_capture = 1'b0;
    logic [31:0] flt_status = '0;
    logic [31:0] flt_addr = '0;
    logic [31:0] pt_base_o, win_mask_o;
    logic        xlat_en_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmat_cfg_regs #(.VERSION(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .flt_capture(flt_capture),
        .flt_status(flt_status), .flt_addr(flt_addr), .pt_base_o(pt_base_o),
        .win_mask_o(win_mask_o), .xlat_en_o(xlat_en_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [13:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_be = 4'hF;
    endtask

    task automatic capture(input logic [31:0] s, input logic [31:0] a);
        @(negedge clk);
        flt_capture = 1'b1; flt_status = s; flt_addr = a;
        @(negedge clk);
        flt_capture = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(14'h0000, 4'hF, rv); chk("R1 ctrl", rv, {VER, 24'h0});
        rd(14'h0004, 4'hF, rv); chk("R1 base", rv, 32'h0);
        rd(14'h1000, 4'hF, rv); chk("R1 fstat", rv, 32'h0080_0000);
        rd(14'h1004, 4'hF, rv); chk("R1 faddr", rv, 32'h0);
        rd(14'h1008, 4'hF, rv); chk("R1 arben", rv, 32'h0000_0003);
        rd(14'h2000, 4'hF, rv); chk("R1 arbit", rv, 32'h0000_0008);
        rd(14'h3018, 4'hF, rv); chk("R1 maskid", rv, 32'h2300_0000);
        rd(14'h101C, 4'hF, rv); chk("R1 slot3", rv, 32'h0);
        chk("R1 win", win_mask_o, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        chk("R1 xlat_en", {31'h0, xlat_en_o}, 32'h0);

        // table: write, then read back
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i].addr, VEC[i].wd, 4'hF);
            rd(VEC[i].addr, 4'hF, rv);
            chk($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].exp);
        end

        // R3 window decode, R2 enable bit
        wr(14'h0000, 32'h0000_0001, 4'hF);
        chk("R3 code0", win_mask_o, 32'hFF00_0000);
        chk("R2 xlat_en", {31'h0, xlat_en_o}, 32'h1);
        wr(14'h0000, 32'h0000_000C, 4'hF);
        chk("R3 code3", win_mask_o, 32'hF800_0000);
        wr(14'h0000, 32'h0000_001C, 4'hF);
        chk("R3 code7", win_mask_o, 32'h8000_0000);
        chk("R4 pt_base_o", pt_base_o, 32'h07FF_FC00);

        // R12 partial strobe / misaligned ignored
        wr(14'h0004, 32'h0000_0000, 4'h3);
        chk("R12 be write", pt_base_o, 32'h07FF_FC00);
        wr(14'h0006, 32'h0000_0000, 4'hF);
        chk("R12 misaligned write", pt_base_o, 32'h07FF_FC00);
        rd(14'h0004, 4'h1, rv); chk("R12 be read", rv, 32'h0);

        // R6 capture, R7 clear by read
        capture(32'h0000_0001, 32'hDEAD_0000);
        chk("R6 irq set", {31'h0, irq_o}, 32'h1);
        rd(14'h1000, 4'h3, rv);
        chk("R12 partial read keeps irq", {31'h0, irq_o}, 32'h1);
        rd(14'h1004, 4'hF, rv); chk("R6 faddr", rv, 32'hDEAD_0000);
        chk("R7 irq clear on read", {31'h0, irq_o}, 32'h0);
        rd(14'h1000, 4'hF, rv); chk("R6 fstat", rv, 32'h0080_0001);

        // R7 clear by write
        capture(32'hFFFF_FFFF, 32'h0000_1000);
        chk("R6 irq set again", {31'h0, irq_o}, 32'h1);
        wr(14'h1004, 32'h0000_0042, 4'hF);
        chk("R7 irq clear on write", {31'h0, irq_o}, 32'h0);

        // R6 capture beats same-cycle write
        @(negedge clk);
        flt_capture = 1'b1; flt_status = 32'h0000_0004; flt_addr = 32'hCAFE_0000;
        bus_addr = 14'h1004; bus_wdata = 32'h1111_1111; bus_be = 4'hF; bus_wr = 1'b1;
        @(negedge clk);
        flt_capture = 1'b0; bus_wr = 1'b0;
        chk("R6 capture wins irq", {31'h0, irq_o}, 32'h1);
        rd(14'h1004, 4'hF, rv); chk("R6 capture wins addr", rv, 32'hCAFE_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule